// File: doc/BRIEF.md
# Periodic Datalog Mission Scheduler

This block sequences a timed logging mission for a temperature recorder. Software loads a start delay (in minutes) and a control byte, then writes a sample interval. That last write arms the mission. The block counts the start delay down on a once-per-minute tick and waits for one more minute boundary. At that boundary it latches the current real-time clock value as the mission start stamp and requests the first conversion.

After the first sample, a conversion is requested every N minute ticks, where N is the programmed interval. Each completed conversion increments two counters: one for the current mission and one for the life of the device. Each completed conversion also writes its result byte into a log of `LOG_DEPTH` entries. A control bit chooses what happens when the log is full: either wrap around and overwrite the oldest data, or stop writing.

The log memory sits inside the block on a single port. A host can read the log at any time, but when the log write and the host read fall in the same cycle, the log write takes the port.

Top module: `datalog_sched`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `mission_active`, `mem_cleared`, `conv_req`, `ts_capture` and `log_we` are 0, and both counters are 0.
- R2: The selector codes are: 0 is delay low byte, 1 is delay high byte, 2 is control, and 3 is interval. Writing a value from 1 to 255 to code 3 while idle arms the mission. In the next cycle `mission_active`=1, `mem_cleared`=0 and `mission_cnt`=0. Writing interval 0 is ignored.
- R3: With a start delay of D minutes, the first sample happens on the (D+1)-th tick after arming, so D=0 means the first tick. In the cycle after that tick, `conv_req` rises and `ts_capture` pulses for exactly one cycle. At the same time `stamp_time` holds the `rtc_time` value seen at that tick.
- R4: After a sample, the next request comes on the N-th following tick, where N is the interval.
- R5: Each `conv_done` that answers a pending request increments `mission_cnt` and `device_cnt` by one in the next cycle. Arming a new mission resets `mission_cnt` but never `device_cnt`.
- R6: In the cycle after an answered `conv_done`, `log_we` pulses for one cycle. `log_wdata` equals `conv_data`, and `log_addr` runs 0, 1, 2, … from the start of each mission.
- R7: With control bit 0 (wrap enable) set, the write after address `LOG_DEPTH`-1 goes to address 0.
- R8: With control bit 0 clear, there are no further `log_we` pulses once `LOG_DEPTH` entries are written. Sampling and both counters continue.
- R9: While a request is pending, minute ticks raise no new request and `conv_req` stays high until `conv_done`. A sample that falls due while a request is pending is dropped, and the interval count restarts from that tick.
- R10: Raising `ext_rd_en` gives `ext_rd_ack`=1 and the stored byte at `ext_rd_addr` in the next cycle. If `log_we` is high in the cycle of the request, the read is refused (`ext_rd_ack`=0).
- R11: Writing control with bit 2 set during a mission ends it. In the next cycle `mission_active`=0 and `conv_req`=0.
- R12: Writing control with bit 1 set while idle sets `mem_cleared` and restarts the log pointer. While a mission runs, writes to the delay, control (other than bit 2) and interval registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| min_tick | input | 1 | One-cycle pulse on each minute boundary |
| rtc_time | input | TIME_W | Current time and date from the clock |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register selector (0 delay lo, 1 delay hi, 2 control, 3 interval) |
| cfg_wdata | input | 8 | Configuration write data |
| conv_req | output | 1 | Conversion request, held until done |
| conv_done | input | 1 | Conversion finished pulse |
| conv_data | input | DATA_W | Conversion result |
| ts_capture | output | 1 | One-cycle pulse when the start stamp is taken |
| stamp_time | output | TIME_W | Mission start stamp |
| mission_active | output | 1 | Mission in progress |
| mem_cleared | output | 1 | Log cleared since the last arming |
| mission_cnt | output | CNT_W | Samples in this mission |
| device_cnt | output | CNT_W | Samples since reset |
| log_we | output | 1 | Log write strobe |
| log_addr | output | ADDR_W | Log write address |
| log_wdata | output | DATA_W | Log write data |
| ext_rd_en | input | 1 | Host read request |
| ext_rd_addr | input | ADDR_W | Host read address |
| ext_rd_ack | output | 1 | Host read granted, data valid |
| ext_rd_data | output | DATA_W | Host read data |

## Verification
The hardest state to reach is the full-log boundary. It lies thousands of samples past arming, and only there do the wrap and stop policies behave differently. The bench reaches it with an interval of 1 and no start delay, answering each request at once, so that every tick produces one logged sample. It walks the full address range twice, once per policy, and checks the first writes beyond the end. The dropped-sample case is reached by holding back `conv_done` across a whole interval of ticks.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam int CFG_W = 8;
  localparam logic [1:0] SEL_DLY_LO = 2'd0;
  localparam logic [1:0] SEL_DLY_HI = 2'd1;
  localparam logic [1:0] SEL_CTRL   = 2'd2;
  localparam logic [1:0] SEL_RATE   = 2'd3;
  localparam int CTRL_WRAP  = 0;
  localparam int CTRL_CLEAR = 1;
  localparam int CTRL_HALT  = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DELAY,
    S_ALIGN,
    S_RUN,
    S_CONV
  } sched_state_t;
endpackage

// File: rtl/dl_min_countdown.sv
module dl_min_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         last
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == W'(1));
endmodule

// File: rtl/dl_log_ptr.sv
module dl_log_ptr #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          advance,
  input  logic          wrap_en,
  output logic [AW-1:0] ptr,
  output logic          full
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      ptr  <= '0;
      full <= 1'b0;
    end else if (advance && !full) begin
      if (ptr == TOP) begin
        ptr <= '0;
        if (!wrap_en) full <= 1'b1;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dl_log_ram.sv
module dl_log_ram #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          ack,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] port_addr;

  assign port_addr = we ? waddr : raddr;

  always_ff @(posedge clk) begin
    if (we) mem[port_addr] <= wdata;
    else if (re) rdata <= mem[port_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) ack <= 1'b0;
    else ack <= re && !we;
  end
endmodule

// File: rtl/datalog_sched.sv
module datalog_sched
  import dl_pkg::*;
#(
  parameter int LOG_DEPTH = 2048,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 24,
  parameter int TIME_W    = 32,
  localparam int ADDR_W   = $clog2(LOG_DEPTH),
  localparam int DELAY_W  = 2 * CFG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              min_tick,
  input  logic [TIME_W-1:0] rtc_time,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              conv_req,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              ts_capture,
  output logic [TIME_W-1:0] stamp_time,
  output logic              mission_active,
  output logic              mem_cleared,
  output logic [CNT_W-1:0]  mission_cnt,
  output logic [CNT_W-1:0]  device_cnt,
  output logic              log_we,
  output logic [ADDR_W-1:0] log_addr,
  output logic [DATA_W-1:0] log_wdata,
  input  logic              ext_rd_en,
  input  logic [ADDR_W-1:0] ext_rd_addr,
  output logic              ext_rd_ack,
  output logic [DATA_W-1:0] ext_rd_data
);
  sched_state_t st_q, st_d;

  logic [DELAY_W-1:0] delay_q;
  logic [CFG_W-1:0]   rate_q;
  logic               wrap_q;

  logic arm, halt, clr, accept, sample_fire;
  logic delay_load, delay_step, delay_last;
  logic rate_load, rate_step, rate_last;
  logic [DELAY_W-1:0] delay_cnt;
  logic [CFG_W-1:0]   rate_cnt;
  logic [ADDR_W-1:0]  ptr;
  logic               full;

  assign arm    = cfg_we && cfg_sel == SEL_RATE && cfg_wdata != '0 && st_q == S_IDLE;
  assign halt   = cfg_we && cfg_sel == SEL_CTRL && cfg_wdata[CTRL_HALT] && st_q != S_IDLE;
  assign clr    = cfg_we && cfg_sel == SEL_CTRL && cfg_wdata[CTRL_CLEAR] && st_q == S_IDLE;
  assign accept = conv_done && st_q == S_CONV && !halt;
  assign sample_fire = min_tick && !halt &&
                       (st_q == S_ALIGN || (st_q == S_RUN && rate_last));

  assign delay_load = arm;
  assign delay_step = min_tick && st_q == S_DELAY && !delay_last;
  assign rate_load  = sample_fire || (min_tick && !halt && st_q == S_CONV && rate_last);
  assign rate_step  = min_tick && (st_q == S_RUN || st_q == S_CONV) && !rate_last;

  dl_min_countdown #(.W(DELAY_W)) u_delay (
    .clk(clk), .rst(rst), .load(delay_load), .load_val(delay_q),
    .step(delay_step), .cnt(delay_cnt), .last(delay_last)
  );

  dl_min_countdown #(.W(CFG_W)) u_rate (
    .clk(clk), .rst(rst), .load(rate_load), .load_val(rate_q),
    .step(rate_step), .cnt(rate_cnt), .last(rate_last)
  );

  dl_log_ptr #(.DEPTH(LOG_DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .restart(arm || clr), .advance(accept),
    .wrap_en(wrap_q), .ptr(ptr), .full(full)
  );

  dl_log_ram #(.DEPTH(LOG_DEPTH), .DW(DATA_W)) u_ram (
    .clk(clk), .rst(rst), .we(log_we), .waddr(log_addr), .wdata(log_wdata),
    .re(ext_rd_en), .raddr(ext_rd_addr), .ack(ext_rd_ack), .rdata(ext_rd_data)
  );

  always_comb begin
    st_d = st_q;
    if (halt) begin
      st_d = S_IDLE;
    end else if (arm) begin
      st_d = (cfg_wdata == '0) ? S_IDLE : ((delay_q == '0) ? S_ALIGN : S_DELAY);
    end else begin
      unique case (st_q)
        S_DELAY: if (min_tick && delay_last) st_d = S_ALIGN;
        S_ALIGN: if (sample_fire) st_d = S_CONV;
        S_RUN:   if (sample_fire) st_d = S_CONV;
        S_CONV:  if (accept) st_d = S_RUN;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= S_IDLE;
    else st_q <= st_d;
  end

  assign mission_active = (st_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      delay_q <= '0;
      rate_q  <= '0;
      wrap_q  <= 1'b0;
    end else if (cfg_we && st_q == S_IDLE) begin
      unique case (cfg_sel)
        SEL_DLY_LO: delay_q[CFG_W-1:0]       <= cfg_wdata;
        SEL_DLY_HI: delay_q[DELAY_W-1:CFG_W] <= cfg_wdata;
        SEL_CTRL:   wrap_q                   <= cfg_wdata[CTRL_WRAP];
        default:    if (cfg_wdata != '0) rate_q <= cfg_wdata;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_req    <= 1'b0;
      ts_capture  <= 1'b0;
      stamp_time  <= '0;
      mem_cleared <= 1'b0;
      mission_cnt <= '0;
      device_cnt  <= '0;
      log_we      <= 1'b0;
      log_addr    <= '0;
      log_wdata   <= '0;
    end else begin
      ts_capture <= sample_fire && st_q == S_ALIGN;
      if (sample_fire && st_q == S_ALIGN) stamp_time <= rtc_time;

      if (halt) conv_req <= 1'b0;
      else if (sample_fire) conv_req <= 1'b1;
      else if (accept) conv_req <= 1'b0;

      if (clr) mem_cleared <= 1'b1;
      else if (arm) mem_cleared <= 1'b0;

      if (arm || clr) mission_cnt <= '0;
      else if (accept) mission_cnt <= mission_cnt + 1'b1;
      if (accept) device_cnt <= device_cnt + 1'b1;

      log_we <= accept && !full;
      if (accept && !full) begin
        log_addr  <= ptr;
        log_wdata <= conv_data;
      end
    end
  end
endmodule

// File: rtl/dl_sched_checker.sv
module dl_sched_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [1:0]       cfg_sel,
  input logic [7:0]       cfg_wdata,
  input logic             conv_done,
  input logic             conv_req,
  input logic             ts_capture,
  input logic             mission_active,
  input logic             mem_cleared,
  input logic [CNT_W-1:0] mission_cnt,
  input logic [CNT_W-1:0] device_cnt,
  input logic             log_we,
  input logic             ext_rd_ack
);
  logic halt_wr;
  assign halt_wr = cfg_we && cfg_sel == 2'd2 && cfg_wdata[2];

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!mission_active && !conv_req && !log_we && !mem_cleared && device_cnt == '0));

  a_r2_arm_flags: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd3 && cfg_wdata != 8'd0 && !mission_active)
      |=> (mission_active && !mem_cleared && mission_cnt == '0));

  a_r2_zero_rate: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd3 && cfg_wdata == 8'd0 && !mission_active) |=> !mission_active);

  a_r3_stamp_pulse: assert property (@(posedge clk) disable iff (rst)
    ts_capture |=> !ts_capture);

  a_r3_stamp_with_req: assert property (@(posedge clk) disable iff (rst)
    ts_capture |-> conv_req);

  a_r5_device_step: assert property (@(posedge clk) disable iff (rst)
    (conv_done && conv_req && !halt_wr) |=> device_cnt == $past(device_cnt) + 1'b1);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    (conv_req && !conv_done && !halt_wr) |=> conv_req);

  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    log_we |=> !ext_rd_ack);

  a_r11_halt: assert property (@(posedge clk) disable iff (rst)
    halt_wr |=> (!mission_active && !conv_req));
endmodule

bind datalog_sched dl_sched_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .conv_done(conv_done), .conv_req(conv_req), .ts_capture(ts_capture),
  .mission_active(mission_active), .mem_cleared(mem_cleared),
  .mission_cnt(mission_cnt), .device_cnt(device_cnt), .log_we(log_we),
  .ext_rd_ack(ext_rd_ack)
);

// File: tb/datalog_sched_bench.sv
module datalog_sched_bench;
  localparam int DEPTH = 2048;
  localparam int AW = 11;
  localparam int CW = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic min_tick = 1'b0;
  logic [31:0] rtc_time = 32'h1000_0000;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic conv_req, conv_done = 1'b0;
  logic [7:0] conv_data = 8'd0;
  logic ts_capture;
  logic [31:0] stamp_time;
  logic mission_active, mem_cleared;
  logic [CW-1:0] mission_cnt, device_cnt;
  logic log_we;
  logic [AW-1:0] log_addr;
  logic [7:0] log_wdata;
  logic ext_rd_en = 1'b0;
  logic [AW-1:0] ext_rd_addr = '0;
  logic ext_rd_ack;
  logic [7:0] ext_rd_data;

  int checks = 0;
  int errors = 0;
  int exp_dev = 0;
  int exp_mis = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  datalog_sched u_datalog_sched (
    .clk(clk), .rst(rst), .min_tick(min_tick), .rtc_time(rtc_time),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .conv_req(conv_req), .conv_done(conv_done), .conv_data(conv_data),
    .ts_capture(ts_capture), .stamp_time(stamp_time),
    .mission_active(mission_active), .mem_cleared(mem_cleared),
    .mission_cnt(mission_cnt), .device_cnt(device_cnt),
    .log_we(log_we), .log_addr(log_addr), .log_wdata(log_wdata),
    .ext_rd_en(ext_rd_en), .ext_rd_addr(ext_rd_addr),
    .ext_rd_ack(ext_rd_ack), .ext_rd_data(ext_rd_data)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cfg(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); rtc_time = rtc_time + 32'd60; min_tick = 1'b1;
    @(negedge clk); min_tick = 1'b0;
  endtask

  task automatic do_conv(input logic [7:0] d);
    @(negedge clk); conv_done = 1'b1; conv_data = d;
    @(negedge clk); conv_done = 1'b0;
    exp_dev++; exp_mis++;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  // one full sample at interval 1: tick, request, answer, log check
  task automatic one_sample(input string req, input int idx, input bit exp_we, input int exp_addr);
    do_tick();
    chk({req, " request"}, conv_req, 1);
    do_conv(pat(idx));
    chk({req, " log_we"}, log_we, exp_we);
    if (exp_we) chk({req, " log_addr"}, log_addr, exp_addr);
    chk({req, " device_cnt"}, device_cnt, exp_dev);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 active", mission_active, 0);
    chk("R1 cleared", mem_cleared, 0);
    chk("R1 conv_req", conv_req, 0);
    chk("R1 log_we", log_we, 0);
    chk("R1 device_cnt", device_cnt, 0);
  endtask

  task automatic t_delayed_mission();
    logic [31:0] t_at;
    do_cfg(2'd0, 8'd2);
    do_cfg(2'd1, 8'd0);
    do_cfg(2'd2, 8'h00);
    do_cfg(2'd3, 8'd0);
    chk("R2 zero interval ignored", mission_active, 0);
    do_cfg(2'd3, 8'd3);
    chk("R2 armed", mission_active, 1);
    chk("R2 cleared low", mem_cleared, 0);
    chk("R2 mission_cnt", mission_cnt, 0);
    exp_mis = 0;
    do_tick(); chk("R3 no req tick1", conv_req, 0);
    do_tick(); chk("R3 no req tick2", conv_req, 0);
    do_tick(); t_at = rtc_time;
    chk("R3 req on tick D+1", conv_req, 1);
    chk("R3 stamp pulse", ts_capture, 1);
    chk("R3 stamp value", stamp_time, t_at);
    do_conv(8'h11);
    chk("R3 stamp one cycle", ts_capture, 0);
    chk("R6 log_we", log_we, 1);
    chk("R6 addr 0", log_addr, 0);
    chk("R6 data", log_wdata, 8'h11);
    chk("R5 mission_cnt", mission_cnt, exp_mis);
    chk("R5 device_cnt", device_cnt, exp_dev);
    // write wins over a host read in the same cycle
    ext_rd_en = 1'b1; ext_rd_addr = '0;
    @(negedge clk); ext_rd_en = 1'b0;
    chk("R10 refused during write", ext_rd_ack, 0);
    chk("R6 log_we one cycle", log_we, 0);
    @(negedge clk); ext_rd_en = 1'b1; ext_rd_addr = '0;
    @(negedge clk); ext_rd_en = 1'b0;
    chk("R10 granted", ext_rd_ack, 1);
    chk("R10 data", ext_rd_data, 8'h11);
    // interval of 3
    do_tick(); chk("R4 no req tick1", conv_req, 0);
    do_tick(); chk("R4 no req tick2", conv_req, 0);
    do_tick(); chk("R4 req tick3", conv_req, 1);
    chk("R4 no stamp later", ts_capture, 0);
    // hold the answer across a whole interval
    do_tick(); do_tick(); do_tick();
    chk("R9 still pending", conv_req, 1);
    do_conv(8'h22);
    chk("R9 single count", device_cnt, exp_dev);
    chk("R6 addr 1", log_addr, 1);
    @(negedge clk);
    chk("R9 req dropped after done", conv_req, 0);
    do_tick(); chk("R9 no req +1", conv_req, 0);
    do_tick(); chk("R9 no req +2", conv_req, 0);
    do_tick(); chk("R9 req +3", conv_req, 1);
    do_conv(8'h33);
    // config ignored while running
    do_cfg(2'd2, 8'h02);
    chk("R12 clear ignored", mem_cleared, 0);
    chk("R12 mission_cnt kept", mission_cnt, exp_mis);
    do_cfg(2'd3, 8'd1);
    do_tick(); chk("R12 interval ignored", conv_req, 0);
    do_tick(); do_tick();
    chk("R12 old interval kept", conv_req, 1);
    do_cfg(2'd2, 8'h04);
    chk("R11 halted", mission_active, 0);
    chk("R11 req dropped", conv_req, 0);
  endtask

  task automatic t_zero_delay();
    do_cfg(2'd2, 8'h02);
    chk("R12 cleared idle", mem_cleared, 1);
    do_cfg(2'd0, 8'd0);
    do_cfg(2'd3, 8'd1);
    exp_mis = 0;
    chk("R2 cleared flag dropped", mem_cleared, 0);
    chk("R5 device_cnt kept", device_cnt, exp_dev);
    chk("R5 mission_cnt reset", mission_cnt, 0);
    do_tick();
    chk("R3 zero delay first tick", conv_req, 1);
    chk("R3 zero delay stamp", ts_capture, 1);
    do_conv(8'h44);
    chk("R6 addr restart", log_addr, 0);
    chk("R5 mission_cnt one", mission_cnt, 1);
    do_cfg(2'd2, 8'h04);
  endtask

  task automatic t_stop_when_full();
    do_cfg(2'd2, 8'h00);
    do_cfg(2'd3, 8'd1);
    exp_mis = 0;
    for (int i = 0; i < DEPTH; i++) one_sample("R8 fill", i, 1'b1, i);
    one_sample("R8 past end", DEPTH, 1'b0, 0);
    one_sample("R8 past end 2", DEPTH + 1, 1'b0, 0);
    chk("R8 mission_cnt continues", mission_cnt, exp_mis);
    @(negedge clk); ext_rd_en = 1'b1; ext_rd_addr = AW'(DEPTH - 1);
    @(negedge clk); ext_rd_en = 1'b0;
    chk("R8 last entry kept", ext_rd_data, pat(DEPTH - 1));
    do_cfg(2'd2, 8'h04);
  endtask

  task automatic t_wrap();
    do_cfg(2'd2, 8'h01);
    do_cfg(2'd3, 8'd1);
    exp_mis = 0;
    for (int i = 0; i < DEPTH + 2; i++) one_sample("R7 wrap", i, 1'b1, i % DEPTH);
    @(negedge clk); ext_rd_en = 1'b1; ext_rd_addr = '0;
    @(negedge clk); ext_rd_en = 1'b0;
    chk("R7 oldest overwritten", ext_rd_data, pat(DEPTH));
    do_cfg(2'd2, 8'h04);
  endtask

  initial begin
    t_reset();
    t_delayed_mission();
    t_zero_delay();
    t_stop_when_full();
    t_wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule